// File: doc/BRIEF.md
# Four-Lane 7:1 Serializer with Clock Lane

This block takes a 28-bit parallel word once per pixel-clock period and sends it out on four serial data lanes at seven bits per lane per period. A fifth lane carries a copy of the pixel clock. That copy is high for four bit times and low for three, and it rises at the first bit slot of every data lane. A receiver can therefore use the clock lane to find where each word starts. The serial logic runs on a bit clock at seven times the pixel rate. The bit clock is an input with a fixed phase relation to the pixel clock. The intended pixel-clock range is 31 to 85 MHz.

The parallel word is captured on the pixel-clock edge that `edge_sel` picks. It then moves into a holding register on the next rising pixel edge. The bit-clock side loads it into four 7-bit shift registers once per period. The 28 input bits are spread over the lanes in a fixed, non-contiguous order. An active-low `shdn_n` resets every register in both clock domains. While it is low, it forces all serial outputs and output enables low.

The integration phase assumed here is as follows. The pixel clock rises half a period away from the bit-clock edge that loads the shift registers. `shdn_n` is released between bit-clock edges.

Top module: `ser7_tx`

## Requirements
- R1: While `shdn_n` is 0, `lane_out`, `clk_lane` and every bit of `lane_oe` are 0. Toggling `par_data`, `edge_sel` or `pix_clk` in this state has no effect on them.
- R2: Lane 0 carries input bits, from its least to its most significant position: 0, 1, 2, 3, 4, 6, 7.
- R3: Lane 1 carries input bits, from its least to its most significant position: 8, 9, 12, 13, 14, 15, 18.
- R4: Lane 2 carries input bits, from its least to its most significant position: 19, 20, 21, 22, 24, 25, 26.
- R5: Lane 3 carries input bits, from its least to its most significant position: 27, 5, 10, 11, 16, 17, 23.
- R6: Each lane sends its seven bits most significant first, one per bit-clock cycle, in slots 0 to 6 of a period.
- R7: With `edge_sel` = 1 the word is sampled on the rising edge of `pix_clk`; with `edge_sel` = 0 it is sampled on the falling edge.
- R8: The shift registers take one parallel load per seven bit-clock cycles (during slot 6) and shift on the other six.
- R9: `clk_lane` is 1 in slots 0 to 3 and 0 in slots 4 to 6. Its rising edge coincides with the most significant bit of every lane.
- R10: The first rising `bit_clk` edge after `shdn_n` goes high opens slot 0: `clk_lane` rises and the outputs are enabled.
- R11: After release, the first two transmitted periods carry all-zero words. The word sampled in pixel period n (counted from the first period after release) is sent in transmitted period n+2.
- R12: While running, all five bits of `lane_oe` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock, seven times the pixel rate |
| pix_clk | input | 1 | Pixel clock that qualifies the parallel word |
| shdn_n | input | 1 | Active-low shutdown and asynchronous reset |
| edge_sel | input | 1 | Capture edge: 1 rising, 0 falling |
| par_data | input | 28 | Parallel word to transmit |
| lane_out | output | 4 | Serial data lanes 0 to 3 |
| clk_lane | output | 1 | Serial clock lane, 4/7 duty |
| lane_oe | output | 5 | Output enables; bits 0 to 3 for data lanes, bit 4 for the clock lane |

## Verification
The bench changes the parallel word between the rising and falling pixel edges. A design that samples on the wrong edge then recovers the decoy value instead of the target. Walking-one words, one per input bit, would expose any swapped or shifted entry in the scattered lane mapping, and a reversed bit order would show up as mirrored lane patterns. The clock lane is checked slot by slot, so a wrong duty or a rise that is off by one slot from the most significant bit is reported. Shutdown is asserted mid-stream and held while the inputs toggle, which catches outputs that stay driven or registers that survive the reset and leak stale words after restart.

// File: rtl/ser7_pkg.sv
package ser7_pkg;
    localparam int LANES    = 4;
    localparam int SER_BITS = 7;
    localparam int WORD_W   = LANES * SER_BITS;
    localparam int CLK_HIGH = 4;

    // Source input bit for a lane position (position 0 = least significant).
    function automatic int src_bit(input int lane, input int pos);
        int r;
        r = 0;
        case (lane)
            0: case (pos)
                   0: r = 0;  1: r = 1;  2: r = 2;  3: r = 3;
                   4: r = 4;  5: r = 6;  default: r = 7;
               endcase
            1: case (pos)
                   0: r = 8;  1: r = 9;  2: r = 12; 3: r = 13;
                   4: r = 14; 5: r = 15; default: r = 18;
               endcase
            2: case (pos)
                   0: r = 19; 1: r = 20; 2: r = 21; 3: r = 22;
                   4: r = 24; 5: r = 25; default: r = 26;
               endcase
            default: case (pos)
                   0: r = 27; 1: r = 5;  2: r = 10; 3: r = 11;
                   4: r = 16; 5: r = 17; default: r = 23;
               endcase
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ser7_capture.sv
module ser7_capture #(
    parameter int WIDTH = 28
) (
    input  logic             pix_clk,
    input  logic             rst_n,
    input  logic             edge_sel,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] word
);
    typedef struct packed {
        logic [WIDTH-1:0] rise;
        logic [WIDTH-1:0] hold;
    } rise_st_t;

    rise_st_t         r_d, r_q;
    logic [WIDTH-1:0] fall_d, fall_q;

    always_comb begin
        r_d.rise = din;
        r_d.hold = edge_sel ? r_q.rise : fall_q;
        fall_d   = din;
    end

    always_ff @(posedge pix_clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(negedge pix_clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= fall_d;
    end

    assign word = r_q.hold;

    // R7: rising mode forwards the rising-edge sample, falling mode the falling-edge sample
    p_rise_source_r7: assert property (@(posedge pix_clk) disable iff (!rst_n)
        $past(edge_sel) |-> word == $past(r_q.rise));
    p_fall_source_r7: assert property (@(posedge pix_clk) disable iff (!rst_n)
        !$past(edge_sel) |-> word == $past(fall_q));
endmodule

// File: rtl/ser7_slot_ctrl.sv
module ser7_slot_ctrl #(
    parameter int SER_BITS = 7,
    parameter int CLK_HIGH = 4
) (
    input  logic bit_clk,
    input  logic rst_n,
    output logic load_n,
    output logic clk_pat,
    output logic run
);
    localparam int            CW       = $clog2(SER_BITS);
    localparam logic [CW-1:0] LAST     = CW'(SER_BITS - 1);
    localparam logic [CW-1:0] HIGH_END = CW'(CLK_HIGH);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          clk;
        logic          run;
    } slot_st_t;

    slot_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.cnt = (s_q.cnt == LAST) ? '0 : s_q.cnt + 1'b1;
        s_d.clk = (s_d.cnt < HIGH_END);
        s_d.run = 1'b1;
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= LAST;
            s_q.clk <= 1'b0;
            s_q.run <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign load_n  = (s_q.cnt != LAST);
    assign clk_pat = s_q.clk;
    assign run     = s_q.run;

    p_slot_range_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
        s_q.cnt <= LAST);
    p_single_load_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !load_n |=> load_n);
    p_clk_rise_slot0_r9: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(s_q.clk) |-> s_q.cnt == '0);
    p_clk_fall_slot_r9: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $fell(s_q.clk) |-> s_q.cnt == HIGH_END);
    p_run_after_release_r10: assert property (@(posedge bit_clk) disable iff (!rst_n)
        1'b1 |=> s_q.run);
endmodule

// File: rtl/ser7_lane.sv
module ser7_lane #(
    parameter int SER_BITS = 7
) (
    input  logic                bit_clk,
    input  logic                rst_n,
    input  logic                load_n,
    input  logic [SER_BITS-1:0] par,
    output logic                sout
);
    logic [SER_BITS-1:0] sh_d, sh_q;

    always_comb begin
        if (!load_n) sh_d = par;
        else         sh_d = {sh_q[SER_BITS-2:0], 1'b0};
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sout = sh_q[SER_BITS-1];

    p_load_word_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !load_n |=> sh_q == $past(par));
    p_msb_first_r6: assert property (@(posedge bit_clk) disable iff (!rst_n)
        load_n |=> sh_q[SER_BITS-1] == $past(sh_q[SER_BITS-2]));
endmodule

// File: rtl/ser7_tx.sv
module ser7_tx
    import ser7_pkg::*;
(
    input  logic                 bit_clk,
    input  logic                 pix_clk,
    input  logic                 shdn_n,
    input  logic                 edge_sel,
    input  logic [WORD_W-1:0]    par_data,
    output logic [LANES-1:0]     lane_out,
    output logic                 clk_lane,
    output logic [LANES:0]       lane_oe
);
    logic [WORD_W-1:0] word_q;
    logic              load_n;
    logic              clk_pat;
    logic              run;
    logic [LANES-1:0]  sout;

    ser7_capture #(.WIDTH(WORD_W)) u_cap (
        .pix_clk  (pix_clk),
        .rst_n    (shdn_n),
        .edge_sel (edge_sel),
        .din      (par_data),
        .word     (word_q)
    );

    ser7_slot_ctrl #(.SER_BITS(SER_BITS), .CLK_HIGH(CLK_HIGH)) u_slot (
        .bit_clk (bit_clk),
        .rst_n   (shdn_n),
        .load_n  (load_n),
        .clk_pat (clk_pat),
        .run     (run)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SER_BITS-1:0] par;
        for (genvar p = 0; p < SER_BITS; p++) begin : g_bit
            assign par[p] = word_q[src_bit(l, p)];
        end
        ser7_lane #(.SER_BITS(SER_BITS)) u_lane (
            .bit_clk (bit_clk),
            .rst_n   (shdn_n),
            .load_n  (load_n),
            .par     (par),
            .sout    (sout[l])
        );
    end

    assign lane_out = sout & {LANES{run}};
    assign clk_lane = clk_pat & run;
    assign lane_oe  = {(LANES + 1){run}};

    p_enables_r12: assert property (@(posedge bit_clk) disable iff (!shdn_n)
        1'b1 |=> lane_oe == {(LANES + 1){1'b1}});
endmodule

// File: tb/ser7_tx_test.sv
module ser7_tx_test;
    localparam int N_WORDS = 40;

    logic        bit_clk = 1'b0;
    logic        pix_clk = 1'b0;
    logic        shdn_n  = 1'b1;
    logic        edge_sel = 1'b1;
    logic [27:0] par_data = '0;
    logic [3:0]  lane_out;
    logic        clk_lane;
    logic [4:0]  lane_oe;

    ser7_tx uut (
        .bit_clk  (bit_clk),
        .pix_clk  (pix_clk),
        .shdn_n   (shdn_n),
        .edge_sel (edge_sel),
        .par_data (par_data),
        .lane_out (lane_out),
        .clk_lane (clk_lane),
        .lane_oe  (lane_oe)
    );

    always #5 bit_clk = ~bit_clk;
    initial begin
        #40;
        forever begin pix_clk = 1'b1; #35; pix_clk = 1'b0; #35; end
    end

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int map_bit(input int lane, input int pos);
        int t0[7] = '{0, 1, 2, 3, 4, 6, 7};
        int t1[7] = '{8, 9, 12, 13, 14, 15, 18};
        int t2[7] = '{19, 20, 21, 22, 24, 25, 26};
        int t3[7] = '{27, 5, 10, 11, 16, 17, 23};
        case (lane)
            0: return t0[pos];
            1: return t1[pos];
            2: return t2[pos];
            default: return t3[pos];
        endcase
    endfunction

    function automatic string lane_req(input int lane);
        case (lane)
            0: return "R2 lane0";
            1: return "R3 lane1";
            2: return "R4 lane2";
            default: return "R5 lane3";
        endcase
    endfunction

    logic [27:0] sent [0:63];
    bit          mon_en  = 1'b0;
    bit          started = 1'b0;
    int          slot    = 0;
    int          rec_cnt = 0;
    logic [6:0]  rx [4];
    logic [27:0] exp_w;
    logic [6:0]  exp_l;

    // deserializer: samples mid-bit, frames on clock-lane rise
    always @(negedge bit_clk) begin
        if (mon_en) begin
            if (!started) begin
                if (clk_lane) begin started = 1'b1; slot = 0; end
            end else begin
                slot = (slot == 6) ? 0 : slot + 1;
            end
            if (started) begin
                chk(clk_lane == (slot < 4), "R9 clock lane slot pattern",
                    32'(clk_lane), 32'(slot < 4));
                for (int l = 0; l < 4; l++) rx[l] = {rx[l][5:0], lane_out[l]};
                if (slot == 6) begin
                    exp_w = (rec_cnt < 2) ? 28'h0 : sent[rec_cnt-2];
                    for (int l = 0; l < 4; l++) begin
                        for (int p = 0; p < 7; p++) exp_l[p] = exp_w[map_bit(l, p)];
                        chk(rx[l] == exp_l,
                            {lane_req(l), " R6 R7 R8 R11 word ", $sformatf("%0d", rec_cnt)},
                            32'(rx[l]), 32'(exp_l));
                    end
                    rec_cnt++;
                end
            end
        end
    end

    task automatic check_off(input string tag);
        chk(lane_out == 4'h0, {"R1 lanes off ", tag}, 32'(lane_out), 32'h0);
        chk(clk_lane == 1'b0, {"R1 clock lane low ", tag}, 32'(clk_lane), 32'h0);
        chk(lane_oe == 5'h00, {"R1 enables off ", tag}, 32'(lane_oe), 32'h0);
    endtask

    task automatic run_mode(input bit es);
        logic [27:0] tgt, decoy;
        edge_sel = es;
        par_data = '0;
        @(negedge pix_clk);
        #67;
        started = 1'b0;
        rec_cnt = 0;
        mon_en  = 1'b1;
        shdn_n  = 1'b1;
        #8;
        chk(clk_lane == 1'b1, "R10 slot 0 opens on first edge", 32'(clk_lane), 32'h1);
        chk(lane_oe == 5'h1F, "R10 R12 enables high", 32'(lane_oe), 32'h1F);
        #10;
        for (int n = 0; n < N_WORDS; n++) begin
            if (n < 28) tgt = 28'h1 << n;
            else if (n == 28) tgt = 28'hFFFFFFF;
            else if (n == 29) tgt = 28'hAAAAAAA;
            else tgt = 28'($urandom);
            decoy = (n < 30) ? ~tgt : 28'($urandom);
            sent[n] = tgt;
            par_data = es ? tgt : decoy;
            #30;
            par_data = es ? decoy : tgt;
            #40;
        end
        wait (rec_cnt == N_WORDS + 2);
        chk(lane_oe == 5'h1F, "R12 enables high while running", 32'(lane_oe), 32'h1F);
        mon_en = 1'b0;
        #3;
        shdn_n = 1'b0;
        #2;
        check_off("mid-stream");
        repeat (6) begin
            par_data = 28'($urandom);
            edge_sel = ~edge_sel;
            #23;
        end
        check_off("inputs toggling");
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #1 shdn_n = 1'b0;
        #29;
        check_off("after reset");
        run_mode(1'b1);
        run_mode(1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule